// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit resolves jump-class instructions in an execution pipeline. Each cycle it takes one decoded jump instruction (a 4-bit jump code, a source-select bit, a compare-width bit, two register values, a 32-bit immediate, a 16-bit offset and the current program counter). One clock later it presents the resolved outcome: the next program counter, a taken flag, an illegal flag, and separate call and exit flags. The program counter counts 64-bit instruction slots, so sequential flow advances it by one.

Comparisons run either on the full 64-bit register values or on their low 32 bits. Unsigned, signed and bit-test conditions are all supported. The second operand is either the source register or the immediate, sign-extended. The unit never acts on call and exit codes itself. It raises a flag and leaves the work to an external controller. Two-slot instructions are merged by the fetch stage before they reach this unit.

Top module: `branch_resolve`

## Requirements
- R1: While `rst_n` is low, all outputs are held at zero.
- R2: Jump code 0x0 with `use_reg`=0 is always taken. When `wide`=1 its displacement is the sign-extended `offs`; when `wide`=0 it is the 32-bit `imm`. Code 0x0 with `use_reg`=1 is illegal.
- R3: Code 0x1 is taken when the operands are equal, 0x5 when they differ, and 0x4 when their bitwise AND is non-zero.
- R4: Codes 0x2 (>), 0x3 (>=), 0xa (<) and 0xb (<=) compare unsigned.
- R5: Codes 0x6 (>), 0x7 (>=), 0xc (<) and 0xd (<=) compare two's-complement signed.
- R6: When `wide`=0, only bits 31:0 of each operand take part, and signed compares use bit 31 as the sign. When `wide`=1, all 64 bits take part.
- R7: When `use_reg`=1 the second operand is `b_val`. When `use_reg`=0 it is `imm` sign-extended to 64 bits.
- R8: A taken instruction gives `next_pc` = `pc` + 1 + displacement. Conditional codes use sign-extended `offs` as the displacement. Any instruction that is not taken gives `pc` + 1. The sum wraps modulo 2^PC_W.
- R9: Code 0x8 raises `is_call` and code 0x9 raises `is_exit`, both not taken. Either is legal only with `wide`=1 and `use_reg`=0; otherwise `illegal` is raised instead.
- R10: Codes 0xe and 0xf raise `illegal`, with `taken`=0 and `next_pc` = `pc` + 1.
- R11: Outputs reflect the inputs of the previous rising clock edge. At most one of `taken`, `illegal`, `is_call` and `is_exit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jcode | input | 4 | Jump operation code |
| use_reg | input | 1 | 1: second operand from `b_val`; 0: from `imm` |
| wide | input | 1 | 1: 64-bit compare class; 0: 32-bit compare class |
| a_val | input | 64 | Destination register value |
| b_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| offs | input | 16 | Offset field |
| pc | input | PC_W | Current slot address |
| next_pc | output | PC_W | Resolved next slot address |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Encoding not allowed |
| is_call | output | 1 | Legal call, for the controller |
| is_exit | output | 1 | Legal exit, for the controller |

## Verification
The assertions check the following on every cycle:
- Outcome flags are mutually exclusive.
- A not-taken result always lands on the sequential slot.
- Codes 0xe and 0xf are always illegal.
- A call flag only follows a legal call encoding.
- An unconditional jump is always taken.
- Equal wide register operands always take code 0x1.

Some behaviour only the bench scenarios can show:
- The exact signed and unsigned ordering in both widths.
- The choice between offset and immediate for the unconditional jump.
- Wraparound of the slot address.
- Sign extension of the immediate.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      jcode,
  input  logic            use_reg,
  input  logic            wide,
  input  logic [63:0]     a_val,
  input  logic [63:0]     b_val,
  input  logic [31:0]     imm,
  input  logic [15:0]     offs,
  input  logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic            illegal,
  output logic            is_call,
  output logic            is_exit
);

  logic [63:0] opb, ua, ub, disp;
  logic signed [63:0] sa, sb;
  logic hit, bad, call_h, exit_h;
  logic [PC_W-1:0] seq_pc, tgt_pc;

  assign opb = use_reg ? b_val : {{32{imm[31]}}, imm};
  assign ua  = wide ? a_val : {32'd0, a_val[31:0]};
  assign ub  = wide ? opb   : {32'd0, opb[31:0]};
  assign sa  = wide ? a_val : {{32{a_val[31]}}, a_val[31:0]};
  assign sb  = wide ? opb   : {{32{opb[31]}}, opb[31:0]};

  always_comb begin
    hit    = 1'b0;
    bad    = 1'b0;
    call_h = 1'b0;
    exit_h = 1'b0;
    disp   = {{48{offs[15]}}, offs};
    case (jcode)
      4'h0: if (use_reg) bad = 1'b1;
            else begin
              hit = 1'b1;
              if (!wide) disp = {{32{imm[31]}}, imm};
            end
      4'h1: hit = (ua == ub);
      4'h2: hit = (ua > ub);
      4'h3: hit = (ua >= ub);
      4'h4: hit = |(ua & ub);
      4'h5: hit = (ua != ub);
      4'h6: hit = (sa > sb);
      4'h7: hit = (sa >= sb);
      4'h8: if (wide && !use_reg) call_h = 1'b1; else bad = 1'b1;
      4'h9: if (wide && !use_reg) exit_h = 1'b1; else bad = 1'b1;
      4'ha: hit = (ua < ub);
      4'hb: hit = (ua <= ub);
      4'hc: hit = (sa < sb);
      4'hd: hit = (sa <= sb);
      default: bad = 1'b1;
    endcase
  end

  assign seq_pc = pc + PC_W'(1);
  assign tgt_pc = seq_pc + disp[PC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc <= '0;
      taken   <= 1'b0;
      illegal <= 1'b0;
      is_call <= 1'b0;
      is_exit <= 1'b0;
    end else begin
      next_pc <= hit ? tgt_pc : seq_pc;
      taken   <= hit;
      illegal <= bad;
      is_call <= call_h;
      is_exit <= exit_h;
    end
  end

endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      jcode,
  input logic            use_reg,
  input logic            wide,
  input logic [63:0]     a_val,
  input logic [63:0]     b_val,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            illegal,
  input logic            is_call,
  input logic            is_exit
);

  logic primed;
  always_ff @(posedge clk) primed <= rst_n;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({taken, illegal, is_call, is_exit}) <= 1); // R11

  AST_SEQ_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !taken |-> next_pc == $past(pc) + PC_W'(1)); // R8

  AST_HIGH_CODE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(jcode) >= 4'he |-> illegal && !taken); // R10

  AST_CALL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    primed && is_call |-> $past(jcode) == 4'h8 && $past(wide) && !$past(use_reg)); // R9

  AST_JA_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(jcode) == 4'h0 && !$past(use_reg) |-> taken); // R2

  AST_EQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(jcode) == 4'h1 && $past(use_reg) && $past(wide) &&
    $past(a_val) == $past(b_val) |-> taken); // R3

endmodule

bind branch_resolve branch_resolve_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .jcode(jcode), .use_reg(use_reg), .wide(wide),
  .a_val(a_val), .b_val(b_val), .pc(pc), .next_pc(next_pc), .taken(taken),
  .illegal(illegal), .is_call(is_call), .is_exit(is_exit)
);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] jcode = '0;
  logic use_reg = 1'b0, wide = 1'b0;
  logic [63:0] a_val = '0, b_val = '0;
  logic [31:0] imm = '0;
  logic [15:0] offs = '0;
  logic [PC_W-1:0] pc = '0;
  logic [PC_W-1:0] next_pc;
  logic taken, illegal, is_call, is_exit;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_resolve #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .jcode(jcode), .use_reg(use_reg), .wide(wide),
    .a_val(a_val), .b_val(b_val), .imm(imm), .offs(offs), .pc(pc),
    .next_pc(next_pc), .taken(taken), .illegal(illegal),
    .is_call(is_call), .is_exit(is_exit)
  );

  function automatic logic [PC_W+3:0] expect_out(
      logic [3:0] c, logic r, logic w, logic [63:0] a, logic [63:0] b,
      logic [31:0] im, logic [15:0] of, logic [PC_W-1:0] p);
    longint unsigned x, y;
    longint sx, sy;
    longint d;
    bit t = 0, il = 0, ca = 0, ex = 0;
    logic [63:0] src;
    logic [PC_W-1:0] np;
    src = r ? b : 64'(signed'(im));
    if (w) begin x = a; y = src; sx = a; sy = src; end
    else begin
      x = {32'd0, a[31:0]}; y = {32'd0, src[31:0]};
      sx = longint'(signed'(a[31:0])); sy = longint'(signed'(src[31:0]));
    end
    d = longint'(signed'(of));
    case (c)
      4'h0: begin il = r; t = !r; if (!w) d = longint'(signed'(im)); end
      4'h1: t = x == y;
      4'h5: t = x != y;
      4'h4: t = (x & y) != 0;
      4'h2: t = x > y;
      4'h3: t = x >= y;
      4'ha: t = x < y;
      4'hb: t = x <= y;
      4'h6: t = sx > sy;
      4'h7: t = sx >= sy;
      4'hc: t = sx < sy;
      4'hd: t = sx <= sy;
      4'h8: begin ca = w && !r; il = !ca; end
      4'h9: begin ex = w && !r; il = !ex; end
      default: il = 1;
    endcase
    np = t ? PC_W'(64'(p) + 64'd1 + 64'(d)) : p + PC_W'(1);
    return {np, t, il, ca, ex};
  endfunction

  function automatic string tag_of(logic [3:0] c, logic w);
    case (c)
      4'h0: return "R2";
      4'h1, 4'h4, 4'h5: return w ? "R3" : "R6";
      4'h2, 4'h3, 4'ha, 4'hb: return w ? "R4" : "R6";
      4'h6, 4'h7, 4'hc, 4'hd: return w ? "R5" : "R6";
      4'h8, 4'h9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_now(string tag, logic [PC_W+3:0] exp);
    logic [PC_W+3:0] got;
    got = {next_pc, taken, illegal, is_call, is_exit};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s code=%h wide=%0b reg=%0b actual=%h expected=%h",
               tag, jcode, wide, use_reg, got, exp);
    end
  endtask

  task automatic run(string tag, logic [3:0] c, logic r, logic w, logic [63:0] a,
                     logic [63:0] b, logic [31:0] im, logic [15:0] of, logic [PC_W-1:0] p);
    jcode = c; use_reg = r; wide = w; a_val = a; b_val = b; imm = im; offs = of; pc = p;
    @(negedge clk);
    check_now(tag, expect_out(c, r, w, a, b, im, of, p));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    jcode = 4'h1; a_val = 64'h5; b_val = 64'h5; use_reg = 1; wide = 1; pc = 32'h40;
    repeat (3) @(negedge clk);
    check_now("R1", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_now("R11", {32'h41, 4'b1000});

    run("R2", 4'h0, 0, 1, 0, 0, 32'h100, 16'hFFFF, 32'd10);
    run("R2", 4'h0, 0, 0, 0, 0, 32'h100, 16'h0003, 32'd5);
    run("R2", 4'h0, 1, 1, 0, 0, 0, 16'h4, 32'd5);
    run("R3", 4'h4, 1, 1, 64'hF0, 64'h0F, 0, 16'h8, 32'd20);
    run("R6", 4'h1, 1, 0, 64'h1_0000_0007, 64'h2_0000_0007, 0, 16'h8, 32'd20);
    run("R6", 4'hc, 1, 0, 64'hFFFF_FFFF, 64'h1, 0, 16'h2, 32'd7);
    run("R6", 4'ha, 1, 0, 64'hFFFF_FFFF, 64'h1, 0, 16'h2, 32'd7);
    run("R5", 4'h6, 1, 1, 64'hFFFF_FFFF, 64'h1, 0, 16'h2, 32'd7);
    run("R5", 4'hd, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 32'hFFFF_FFFF, 16'h9, 32'd3);
    run("R7", 4'h1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'h1, 32'd3);
    run("R4", 4'h3, 1, 1, 64'h8000_0000_0000_0000, 64'h1, 0, 16'hFFF0, 32'd100);
    run("R9", 4'h8, 0, 1, 0, 0, 32'h77, 0, 32'd50);
    run("R9", 4'h8, 0, 0, 0, 0, 32'h77, 0, 32'd50);
    run("R9", 4'h9, 0, 1, 0, 0, 0, 0, 32'd51);
    run("R9", 4'h9, 1, 1, 0, 0, 0, 0, 32'd51);
    run("R10", 4'he, 1, 1, 1, 1, 0, 16'h5, 32'd60);
    run("R10", 4'hf, 0, 0, 0, 0, 0, 16'h5, 32'd61);
    run("R8", 4'h5, 1, 1, 1, 1, 0, 16'h5, 32'hFFFF_FFFF);
    run("R8", 4'h0, 0, 1, 0, 0, 0, 16'h0001, 32'hFFFF_FFFE);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] c;
      logic r, w;
      logic [63:0] a, b;
      int sel;
      c = 4'($urandom); r = 1'($urandom); w = 1'($urandom);
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      sel = int'($urandom % 4);
      if (sel == 0) b = a;
      else if (sel == 1) begin a = 64'($urandom % 4); b = 64'($urandom % 4); end
      else if (sel == 2) b = {a[63:32] ^ 32'h8000_0000, a[31:0]};
      run(tag_of(c, w), c, r, w, a, b, $urandom, 16'($urandom), $urandom);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule